// File: doc/BRIEF.md
# Per-Sample Rate Resolver with Signaling-Frame Override

This block serves one channel of a voice transcoder. It sits between the channel's configuration bits and the coding engine. The block runs on the channel's bit clock. It watches frame sync, and the end of each frame-sync pulse marks the start of a new sample. At that point it takes a snapshot of the configuration. From the snapshot it resolves the coding rate and the channel mode that the engine uses for the whole sample. A register write can therefore change the rate on the fly, and the new rate takes effect from the next sample.

While frame sync is high, the block counts the bit-clock edges to measure the pulse width. A pulse of two or more bit periods marks a signaling frame. If the channel is programmed for 32 kbps and a signaling frame arrives, the block drops the rate to 24 kbps for that one sample. It also raises a flag that says the least significant bit of the compressed word is free for signaling data.

Two sources can set the base rate:
- In software mode, a three-bit select code sets the rate.
- In hardware mode, two strap pins set it. The block remembers whether both pins were low when reset was released, and this history is what selects 24 kbps.

The block also turns an algorithm-reset request into a single-cycle pulse to the engine. It returns a done pulse one cycle later so that the register block can clear the request.

Top module: `alg_sel_cas`

## Requirements
- R1: In software mode the select code sets the base rate. 3'b000 gives 32 kbps, 3'b111 gives 24 kbps and 3'b101 gives 16 kbps, and every other code gives 32 kbps. On `rate_o`, 32 kbps is 2'd0, 24 kbps is 2'd1 and 16 kbps is 2'd2.
- R2: Configuration is sampled only at a sample start. A sample start is the first rising clock edge at which `fsync` is seen low after being high. `rate_o`, `mode_o` and `sig_slot_o` keep their values between sample starts, whatever the configuration inputs do.
- R3: The frame-sync width is the number of rising edges at which `fsync` is high. A width of 1 is a normal frame. A width of 2 or more is a signaling frame, and this includes widths longer than the counter range.
- R4: If the base rate is 32 kbps and the frame is a signaling frame, `rate_o` becomes 2'd1 for that sample and `sig_slot_o` is 1. This applies in both hardware and software mode.
- R5: A signaling frame has no effect when the base rate is 24 or 16 kbps. The rate stays as programmed and `sig_slot_o` stays 0. `sig_slot_o` is also 0 after any normal frame.
- R6: `mode_o` is 2'd3 (idle) when idle is set. Otherwise it is 2'd2 (bypass) when bypass is set. Otherwise it is 2'd1 (compress) or 2'd0 (expand), following the coding bit.
- R7: In hardware mode the bypass input has no effect on `mode_o`.
- R8: In hardware mode the base rate comes from the straps. Both low gives 32 kbps. Mixed gives 32 kbps. Both high gives 24 kbps if both were low at the first clock edge after reset, and 16 kbps otherwise.
- R9: A rising request on `alrst_req` gives one `alg_reset_o` pulse that lasts one cycle. `alrst_done_o` follows in the next cycle. No further pulse occurs while the request stays high.
- R10: After reset, `rate_o` is 2'd0, `mode_o` is 2'd3, and `sig_slot_o`, `alg_reset_o` and `alrst_done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode | input | 1 | 1 = strap-driven hardware mode |
| sel_code | input | 3 | Software rate select code |
| strap_a | input | 1 | First rate strap (hardware mode) |
| strap_b | input | 1 | Second rate strap (hardware mode) |
| cfg_idle | input | 1 | Channel idle |
| cfg_bypass | input | 1 | Channel bypass |
| cfg_compress | input | 1 | 1 = compress, 0 = expand |
| alrst_req | input | 1 | Algorithm-reset request level |
| fsync | input | 1 | Frame sync |
| rate_o | output | 2 | Effective rate for the current sample |
| mode_o | output | 2 | Effective channel mode for the current sample |
| sig_slot_o | output | 1 | LSB of the coded word is free for signaling |
| alg_reset_o | output | 1 | One-cycle algorithm reset to the engine |
| alrst_done_o | output | 1 | One-cycle completion back to the register block |

## Verification
The bench builds the block with a 3-bit width counter, which saturates at 7, and a signaling threshold of 2. With this small counter, a directed pulse of nine bit periods pushes the count past saturation, so the check covers the case where a long signaling pulse must still read as wide. Random frames of width 1 to 3 are mixed with all eight select codes, so the threshold, the override and the undefined codes all fall on both sides of their decisions. Separate resets with each strap history cover all three hardware-mode rates.

// File: rtl/alsel_pkg.sv
package alsel_pkg;

  typedef enum logic [1:0] {
    RATE_32 = 2'd0,
    RATE_24 = 2'd1,
    RATE_16 = 2'd2
  } rate_e;

  typedef enum logic [1:0] {
    MD_EXPAND   = 2'd0,
    MD_COMPRESS = 2'd1,
    MD_BYPASS   = 2'd2,
    MD_IDLE     = 2'd3
  } mode_e;

  // Software select code to base rate; undefined codes fall back to 32k.
  function automatic rate_e sw_rate(input logic [2:0] code);
    case (code)
      3'b111:  return RATE_24;
      3'b101:  return RATE_16;
      default: return RATE_32;
    endcase
  endfunction

  // Strap pair to base rate, using the history captured after reset.
  function automatic rate_e strap_rate(input logic a, input logic b,
                                       input logic low_at_start);
    if (a && b) return low_at_start ? RATE_24 : RATE_16;
    return RATE_32;
  endfunction

  // Signaling frames steal the LSB only from the 32k coder.
  function automatic rate_e apply_cas(input rate_e base, input logic wide);
    return (wide && base == RATE_32) ? RATE_24 : base;
  endfunction

  function automatic mode_e pick_mode(input logic idle, input logic byp,
                                      input logic cp, input logic hw);
    if (idle)        return MD_IDLE;
    if (byp && !hw)  return MD_BYPASS;
    return cp ? MD_COMPRESS : MD_EXPAND;
  endfunction

endpackage

// File: rtl/fs_width_meter.sv
module fs_width_meter #(
  parameter int CNT_W   = 3,
  parameter int SIG_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  output logic sample_evt,
  output logic wide
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] THRESH  = CNT_W'(SIG_MIN);

  logic             fs_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q <= 1'b0;
      cnt  <= '0;
    end else begin
      fs_q <= fsync;
      if (fsync && !fs_q)                 cnt <= CNT_W'(1);
      else if (fsync && cnt != CNT_MAX)   cnt <= cnt + CNT_W'(1);
    end
  end

  // Falling edge of frame sync seen: the pulse width is now final.
  assign sample_evt = fs_q && !fsync;
  assign wide       = sample_evt && (cnt >= THRESH);

  // R3: a wide verdict needs frame sync high on the two previous edges
  p_wide_needs_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> ($past(fsync, 1) && $past(fsync, 2)));

  // R3: a one-edge pulse never reads as wide
  p_narrow_not_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && !$past(fsync, 2)) |-> !wide);

endmodule

// File: rtl/strap_rate_latch.sv
module strap_rate_latch
  import alsel_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  strap_a,
  input  logic  strap_b,
  output rate_e hw_rate
);
  logic init_done;
  logic low_at_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_done    <= 1'b0;
      low_at_start <= 1'b0;
    end else if (!init_done) begin
      init_done    <= 1'b1;
      low_at_start <= !strap_a && !strap_b;
    end
  end

  assign hw_rate = strap_rate(strap_a, strap_b, low_at_start);

  // R8: the strap history is fixed once the first edge has passed
  p_history_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> $stable(low_at_start));

  // R8: mixed straps never select a reduced rate
  p_mixed_is_32_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_a != strap_b) |-> hw_rate == RATE_32);

endmodule

// File: rtl/alrst_pulser.sv
module alrst_pulser (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pulse,
  output logic done
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      pulse <= 1'b0;
      done  <= 1'b0;
    end else begin
      req_q <= req;
      pulse <= req && !req_q;
      done  <= pulse;
    end
  end

  // R9: the reset pulse lasts exactly one cycle
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R9: completion follows the pulse by one cycle
  p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> done);

endmodule

// File: rtl/alg_sel_cas.sv
module alg_sel_cas
  import alsel_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int SIG_MIN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_mode,
  input  logic [2:0] sel_code,
  input  logic       strap_a,
  input  logic       strap_b,
  input  logic       cfg_idle,
  input  logic       cfg_bypass,
  input  logic       cfg_compress,
  input  logic       alrst_req,
  input  logic       fsync,
  output logic [1:0] rate_o,
  output logic [1:0] mode_o,
  output logic       sig_slot_o,
  output logic       alg_reset_o,
  output logic       alrst_done_o
);
  logic  sample_evt;
  logic  wide;
  rate_e hw_rate;
  rate_e base_rate;
  rate_e rate_q;
  mode_e mode_q;
  logic  sig_q;

  fs_width_meter #(.CNT_W(CNT_W), .SIG_MIN(SIG_MIN)) meter_i (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .sample_evt(sample_evt), .wide(wide)
  );

  strap_rate_latch strap_i (
    .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
    .hw_rate(hw_rate)
  );

  alrst_pulser pulser_i (
    .clk(clk), .rst_n(rst_n), .req(alrst_req),
    .pulse(alg_reset_o), .done(alrst_done_o)
  );

  assign base_rate = hw_mode ? hw_rate : sw_rate(sel_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_32;
      mode_q <= MD_IDLE;
      sig_q  <= 1'b0;
    end else if (sample_evt) begin
      rate_q <= apply_cas(base_rate, wide);
      mode_q <= pick_mode(cfg_idle, cfg_bypass, cfg_compress, hw_mode);
      sig_q  <= wide && (base_rate == RATE_32);
    end
  end

  assign rate_o     = rate_q;
  assign mode_o     = mode_q;
  assign sig_slot_o = sig_q;

  // R2: outputs move only on a sample start
  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_evt |=> ($stable(rate_o) && $stable(mode_o) && $stable(sig_slot_o)));

  // R4: a signaling slot always comes with the 24k rate
  p_slot_means_24_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sig_slot_o |-> rate_o == 2'd1);

  // R5: a normal frame never flags a signaling slot
  p_narrow_no_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && !wide) |=> !sig_slot_o);

  // R7: hardware mode never reports bypass
  p_hw_no_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && hw_mode) |=> mode_o != 2'd2);

endmodule

// File: tb/alg_sel_cas_tb_top.sv
module alg_sel_cas_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_mode = 1'b0;
  logic [2:0] sel_code = 3'b000;
  logic       strap_a = 1'b0, strap_b = 1'b0;
  logic       cfg_idle = 1'b0, cfg_bypass = 1'b0, cfg_compress = 1'b0;
  logic       alrst_req = 1'b0;
  logic       fsync = 1'b0;
  logic [1:0] rate_o, mode_o;
  logic       sig_slot_o, alg_reset_o, alrst_done_o;

  int n_chk = 0;
  int n_fail = 0;
  logic strap_hist = 1'b0;

  always #2 clk = ~clk;

  alg_sel_cas #(.CNT_W(3), .SIG_MIN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .sel_code(sel_code),
    .strap_a(strap_a), .strap_b(strap_b), .cfg_idle(cfg_idle),
    .cfg_bypass(cfg_bypass), .cfg_compress(cfg_compress),
    .alrst_req(alrst_req), .fsync(fsync), .rate_o(rate_o), .mode_o(mode_o),
    .sig_slot_o(sig_slot_o), .alg_reset_o(alg_reset_o),
    .alrst_done_o(alrst_done_o)
  );

  // Bench model, written in kbps rather than codes.
  function automatic int kbps_of(input logic hw, input logic [2:0] c,
                                 input logic a, input logic b, input logic hist);
    if (hw) begin
      if (a & b) return hist ? 24 : 16;
      return 32;
    end
    if (c == 3'b111) return 24;
    if (c == 3'b101) return 16;
    return 32;
  endfunction

  function automatic logic [1:0] code_of(input int k);
    return (k == 24) ? 2'd1 : (k == 16) ? 2'd2 : 2'd0;
  endfunction

  function automatic logic [1:0] exp_mode(input logic idl, input logic byp,
                                          input logic cp, input logic hw);
    if (idl) return 2'd3;
    if (byp & ~hw) return 2'd2;
    return {1'b0, cp};
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input int w);
    repeat (w) begin @(negedge clk); fsync = 1'b1; end
    @(negedge clk); fsync = 1'b0;
    @(negedge clk);
  endtask

  // Runs a frame and checks all three sample outputs against the model.
  task automatic frame_check(input string tag, input int w);
    int k;
    logic wd;
    k = kbps_of(hw_mode, sel_code, strap_a, strap_b, strap_hist);
    wd = (w >= 2);
    frame(w);
    check({tag, " rate"}, rate_o, code_of((wd && k == 32) ? 24 : k));
    check({tag, " slot"}, {1'b0, sig_slot_o}, {1'b0, wd && k == 32});
    check({tag, " mode"}, mode_o, exp_mode(cfg_idle, cfg_bypass, cfg_compress, hw_mode));
  endtask

  task automatic do_reset(input logic a, input logic b);
    @(negedge clk);
    rst_n = 1'b0; strap_a = a; strap_b = b;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    strap_hist = ~a & ~b;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2165));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset values
    check("R10 rate", rate_o, 2'd0);
    check("R10 mode", mode_o, 2'd3);
    check("R10 flags", {sig_slot_o, alg_reset_o}, 2'b00);
    check("R10 done", {1'b0, alrst_done_o}, 2'd0);

    // R1 directed decode of every code with normal frames
    for (int c = 0; c < 8; c++) begin
      sel_code = 3'(c);
      frame_check("R1", 1);
    end

    // R3 boundary widths and saturation; R4 override at 32k
    sel_code = 3'b000;
    frame_check("R3 w1", 1);
    frame_check("R3 w2 R4", 2);
    frame_check("R3 w9 sat R4", 9);
    // R5 no override at 24k and 16k
    sel_code = 3'b111; frame_check("R5 24k", 2);
    sel_code = 3'b101; frame_check("R5 16k", 3);

    // R2 on-the-fly: inputs change but no frame, outputs hold
    sel_code = 3'b000; frame_check("R2 setup", 1);
    @(negedge clk);
    sel_code = 3'b101; cfg_idle = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 rate hold", rate_o, 2'd0);
    check("R2 mode hold", mode_o, 2'd0);
    frame_check("R2 next sample", 1);
    cfg_idle = 1'b0;

    // R6 priority
    cfg_bypass = 1'b1; cfg_compress = 1'b1; frame_check("R6 bypass", 1);
    cfg_idle = 1'b1; frame_check("R6 idle", 1);
    cfg_idle = 1'b0; cfg_bypass = 1'b0; frame_check("R6 compress", 1);

    // Random mix: R1 R3 R4 R5 R6
    for (int i = 0; i < 60; i++) begin
      sel_code     = 3'($urandom_range(0, 7));
      cfg_idle     = ($urandom_range(0, 3) == 0);
      cfg_bypass   = ($urandom_range(0, 2) == 0);
      cfg_compress = 1'($urandom_range(0, 1));
      frame_check("R1/R4/R5/R6 rnd", $urandom_range(1, 3));
    end
    cfg_idle = 1'b0; cfg_bypass = 1'b0;

    // R9 algorithm reset pulse
    @(negedge clk); alrst_req = 1'b1;
    @(negedge clk);
    check("R9 pulse", {alg_reset_o, alrst_done_o}, 2'b10);
    @(negedge clk);
    check("R9 done", {alg_reset_o, alrst_done_o}, 2'b01);
    repeat (3) @(negedge clk);
    check("R9 no repeat", {alg_reset_o, alrst_done_o}, 2'b00);
    alrst_req = 1'b0;
    repeat (2) @(negedge clk);
    alrst_req = 1'b1;
    @(negedge clk);
    check("R9 second pulse", {alg_reset_o, alrst_done_o}, 2'b10);
    alrst_req = 1'b0;

    // R8 hardware straps; R7 bypass ignored; R4 override in hw mode
    hw_mode = 1'b1;
    do_reset(1'b0, 1'b0);
    frame_check("R8 low 32k", 1);
    frame_check("R8 R4 hw cas", 2);
    strap_a = 1'b1; frame_check("R8 mixed", 1);
    strap_b = 1'b1; frame_check("R8 24k", 1);
    cfg_bypass = 1'b1; frame_check("R7 bypass ignored", 2);
    cfg_bypass = 1'b0;
    do_reset(1'b1, 1'b1);
    frame_check("R8 16k", 1);
    frame_check("R8 R5 16k cas", 2);
    for (int i = 0; i < 20; i++) begin
      strap_a = 1'($urandom_range(0, 1));
      strap_b = 1'($urandom_range(0, 1));
      cfg_bypass = 1'($urandom_range(0, 1));
      frame_check("R7/R8 rnd", $urandom_range(1, 3));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule